// File: doc/BRIEF.md
# Programmed I/O Gate-Return Responder

This block sits on the device side of a programmed I/O handshake. When the channel raises its address gate with an address that selects this device, the responder waits a set number of cycles and raises gate-return. While gate-return is up and the command is active, it drives the condition-code-in bus. On a read command it also drives the data bus. On a write command, the rising edge of the data strobe captures the write data and hands it on through a valid/ready stream.

The strobe may stay high after the gate has fallen, so a falling gate does not end the transfer. Release starts at the first clock edge that sees both gate and strobe low. The responder then drops its bus enables and pulses command-complete. A cleanup step of fixed length follows, shown on `cleanup_o`, and gate-return drops last. If the write data has not yet been accepted, gate-return stays up until the consumer takes it.

Back-pressure rules for the write stream: `wr_valid_o` stays high with `wr_data_o` unchanged until a cycle in which `wr_ready_i` is high. The consumer must accept within `READY_MAX` cycles. An elaboration check confirms that the cleanup length plus that allowance fits inside the release time limit, which is given in nanoseconds.

Top module: `gret_responder`

## Requirements
- R1: After reset, `gret_o`, `dbus_en_o`, `cc_en_o`, `wr_valid_o`, `done_o` and `cleanup_o` are all low.
- R2: If the gate is sampled high at clock edge k with `addr_i` equal to `DEV_ADDR`, `gret_o` rises after edge k+`ACK_DLY`. For any other address, `gret_o` stays low.
- R3: While the command is active, `cc_en_o` is high and `cc_o` carries `cc_src_i` as it was on entry. On a read (`rd_cmd_i`=1 at gate acceptance), `dbus_en_o` is high and `dbus_o` carries `rdata_src_i` as it was on entry. On a write, `dbus_en_o` is low.
- R4: A gate that falls while the strobe is still high does not start the release: `gret_o` and `cc_en_o` stay high until the strobe also falls.
- R5: At the first edge that samples both gate and strobe low, `cc_en_o` and `dbus_en_o` drop and `done_o` is high for exactly one cycle.
- R6: After the bus release, `cleanup_o` is high for exactly `CLEAN_CYC` cycles, and `gret_o` drops `CLEAN_CYC`+1 cycles after the bus enables drop. The bus enables always drop strictly before `gret_o`.
- R7: On a write, the strobe's rising edge captures `wdata_i` into `wr_data_o` with `wr_valid_o` high. Both hold until accepted. Exactly one word is produced per write command, and none is produced for a read.
- R8: While the write word is still pending, `gret_o` stays high. It falls one cycle after the cycle in which the word is accepted.
- R9: Gate-return falls within `T5_NS` of both inputs going low. This is checked at elaboration from `CLEAN_CYC`, `READY_MAX` and `CLK_NS`, and at run time by measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| agate_i | input | 1 | Address gate from the channel |
| addr_i | input | ADDR_W | Device address |
| rd_cmd_i | input | 1 | 1 = read command, 0 = write command |
| strobe_i | input | 1 | Data strobe from the channel |
| wdata_i | input | DATA_W | Write data from the channel |
| rdata_src_i | input | DATA_W | Read data supplied by the device |
| cc_src_i | input | CC_W | Condition code supplied by the device |
| wr_ready_i | input | 1 | Write stream ready |
| gret_o | output | 1 | Gate-return acknowledgement |
| dbus_o | output | DATA_W | Read data bus value |
| dbus_en_o | output | 1 | Read data bus drive enable |
| cc_o | output | CC_W | Condition-code-in bus value |
| cc_en_o | output | 1 | Condition-code bus drive enable |
| wr_valid_o | output | 1 | Write stream valid |
| wr_data_o | output | DATA_W | Write stream data |
| done_o | output | 1 | Command-complete pulse |
| cleanup_o | output | 1 | Post-strobe cleanup step active |

## Verification
The sweep covers every address with both command directions. This separates a correct address match from false responses, and the read bus drive from the write capture. For each case, the strobe falls zero, one or two cycles after the gate. This separates a design that correctly waits for both inputs to go low from one that releases on the gate alone. A final case holds write ready low through the cleanup step, which shows whether gate-return waits for the pending word and then drops exactly one cycle after acceptance.

// File: rtl/gret_pkg.sv
`timescale 1ns/1ps
package gret_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ACK   = 2'd2,
    ST_CLEAN = 2'd3
  } gr_state_e;
endpackage

// File: rtl/gret_ctrl.sv
`timescale 1ns/1ps
module gret_ctrl
  import gret_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DEV_ADDR  = 0,
  parameter int ACK_DLY   = 2,
  parameter int CLEAN_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              agate_i,
  input  logic              strobe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_cmd_i,
  input  logic              pend_i,
  output gr_state_e         state_o,
  output logic              rd_o,
  output logic              load_o,
  output logic              done_o,
  output logic              cleanup_o
);
  localparam int MAXC = (ACK_DLY > CLEAN_CYC) ? ACK_DLY : CLEAN_CYC;
  localparam int CNT_W = $clog2(MAXC + 1) + 1;
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(DEV_ADDR);
  localparam logic [CNT_W-1:0] ACK_LAST = CNT_W'(ACK_DLY - 1);
  localparam logic [CNT_W-1:0] CLEAN_END = CNT_W'(CLEAN_CYC);

  gr_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rd_q, rd_d;
  logic             done_q;
  logic             both_low;

  assign both_low = !agate_i && !strobe_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rd_d    = rd_q;
    load_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (agate_i && (addr_i == MY_ADDR)) begin
          state_d = ST_WAIT;
          cnt_d   = '0;
          rd_d    = rd_cmd_i;
        end
      end
      ST_WAIT: begin
        if (both_low) begin
          state_d = ST_IDLE;
        end else if (cnt_q == ACK_LAST) begin
          state_d = ST_ACK;
          load_o  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_ACK: begin
        if (both_low) begin
          state_d = ST_CLEAN;
          cnt_d   = '0;
        end
      end
      ST_CLEAN: begin
        if ((cnt_q >= CLEAN_END) && !pend_i) begin
          state_d = ST_IDLE;
        end else if (cnt_q < CLEAN_END) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rd_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rd_q    <= rd_d;
      done_q  <= (state_q == ST_ACK) && both_low;
    end
  end

  assign state_o   = state_q;
  assign rd_o      = rd_q;
  assign done_o    = done_q;
  assign cleanup_o = (state_q == ST_CLEAN) && (cnt_q < CLEAN_END);
endmodule

// File: rtl/gret_wcap.sv
`timescale 1ns/1ps
module gret_wcap #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              strobe_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_ready_i,
  output logic              wr_valid_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic              strobe_q;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic              rise;

  assign rise = strobe_i && !strobe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      valid_q  <= 1'b0;
      data_q   <= '0;
    end else begin
      strobe_q <= strobe_i;
      if (valid_q && wr_ready_i) begin
        valid_q <= 1'b0;
      end else if (!valid_q && arm_i && rise) begin
        valid_q <= 1'b1;
        data_q  <= wdata_i;
      end
    end
  end

  assign wr_valid_o = valid_q;
  assign wr_data_o  = data_q;
endmodule

// File: rtl/gret_drive.sv
`timescale 1ns/1ps
module gret_drive #(
  parameter int DATA_W = 16,
  parameter int CC_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              bus_on_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] rdata_src_i,
  input  logic [CC_W-1:0]   cc_src_i,
  output logic [DATA_W-1:0] dbus_o,
  output logic              dbus_en_o,
  output logic [CC_W-1:0]   cc_o,
  output logic              cc_en_o
);
  logic [DATA_W-1:0] rd_hold_q;
  logic [CC_W-1:0]   cc_hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_hold_q <= '0;
      cc_hold_q <= '0;
    end else if (load_i) begin
      rd_hold_q <= rdata_src_i;
      cc_hold_q <= cc_src_i;
    end
  end

  assign cc_en_o   = bus_on_i;
  assign dbus_en_o = bus_on_i && rd_i;
  assign cc_o      = bus_on_i ? cc_hold_q : '0;
  assign dbus_o    = (bus_on_i && rd_i) ? rd_hold_q : '0;
endmodule

// File: rtl/gret_responder.sv
`timescale 1ns/1ps
module gret_responder
  import gret_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int CC_W      = 3,
  parameter int DEV_ADDR  = 5,
  parameter int ACK_DLY   = 2,
  parameter int CLEAN_CYC = 3,
  parameter int READY_MAX = 8,
  parameter int CLK_NS    = 5,
  parameter int T5_NS     = 3000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              agate_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_cmd_i,
  input  logic              strobe_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] rdata_src_i,
  input  logic [CC_W-1:0]   cc_src_i,
  input  logic              wr_ready_i,
  output logic              gret_o,
  output logic [DATA_W-1:0] dbus_o,
  output logic              dbus_en_o,
  output logic [CC_W-1:0]   cc_o,
  output logic              cc_en_o,
  output logic              wr_valid_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              done_o,
  output logic              cleanup_o
);
  localparam int WINDOW_CYC = CLEAN_CYC + 2 + READY_MAX;

  if (WINDOW_CYC * CLK_NS > T5_NS) begin : g_window_too_long
    $error("release window of %0d cycles exceeds the T5 limit", WINDOW_CYC);
  end
  if (ACK_DLY < 1) begin : g_ack_dly_bad
    $error("ACK_DLY must be at least 1");
  end

  gr_state_e state;
  logic      rd_cmd;
  logic      load;

  gret_ctrl #(
    .ADDR_W   (ADDR_W),
    .DEV_ADDR (DEV_ADDR),
    .ACK_DLY  (ACK_DLY),
    .CLEAN_CYC(CLEAN_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .agate_i  (agate_i),
    .strobe_i (strobe_i),
    .addr_i   (addr_i),
    .rd_cmd_i (rd_cmd_i),
    .pend_i   (wr_valid_o),
    .state_o  (state),
    .rd_o     (rd_cmd),
    .load_o   (load),
    .done_o   (done_o),
    .cleanup_o(cleanup_o)
  );

  gret_wcap #(.DATA_W(DATA_W)) u_wcap (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     ((state == ST_ACK) && !rd_cmd),
    .strobe_i  (strobe_i),
    .wdata_i   (wdata_i),
    .wr_ready_i(wr_ready_i),
    .wr_valid_o(wr_valid_o),
    .wr_data_o (wr_data_o)
  );

  gret_drive #(.DATA_W(DATA_W), .CC_W(CC_W)) u_drive (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .bus_on_i   (state == ST_ACK),
    .rd_i       (rd_cmd),
    .rdata_src_i(rdata_src_i),
    .cc_src_i   (cc_src_i),
    .dbus_o     (dbus_o),
    .dbus_en_o  (dbus_en_o),
    .cc_o       (cc_o),
    .cc_en_o    (cc_en_o)
  );

  assign gret_o = (state == ST_ACK) || (state == ST_CLEAN);
endmodule

// File: rtl/gret_responder_chk.sv
`timescale 1ns/1ps
module gret_responder_chk #(
  parameter int CLK_NS = 5,
  parameter int T5_NS  = 3000
) (
  input logic clk,
  input logic rst_n,
  input logic agate_i,
  input logic strobe_i,
  input logic wr_ready_i,
  input logic gret_o,
  input logic dbus_en_o,
  input logic cc_en_o,
  input logic wr_valid_o,
  input logic [7:0] wr_data_lo,
  input logic done_o
);
  localparam int T5_CYC = T5_NS / CLK_NS;
  logic [15:0] rel_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || agate_i || strobe_i || !gret_o) rel_cnt <= '0;
    else if (rel_cnt != 16'hFFFF) rel_cnt <= rel_cnt + 1'b1;
  end

  assert_bus_inside_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_en_o || dbus_en_o) |-> gret_o);
  assert_release_both_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cc_en_o) |-> (!$past(agate_i) && !$past(strobe_i)));
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_bus_before_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gret_o) |-> (!$past(cc_en_o) && !$past(dbus_en_o)));
  assert_wr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_data_lo)));
  assert_hold_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gret_o && !cc_en_o && wr_valid_o) |=> gret_o);
  assert_t5_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rel_cnt <= 16'(T5_CYC));
endmodule

bind gret_responder gret_responder_chk #(.CLK_NS(CLK_NS), .T5_NS(T5_NS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .agate_i   (agate_i),
  .strobe_i  (strobe_i),
  .wr_ready_i(wr_ready_i),
  .gret_o    (gret_o),
  .dbus_en_o (dbus_en_o),
  .cc_en_o   (cc_en_o),
  .wr_valid_o(wr_valid_o),
  .wr_data_lo(wr_data_o[7:0]),
  .done_o    (done_o)
);

// File: tb/gret_responder_bench.sv
`timescale 1ns/1ps
module gret_responder_bench;
  localparam int ADDR_W = 4, DATA_W = 8, CC_W = 3, DEV = 5;
  localparam int ACKD = 2, CLEAN = 3, CLKNS = 5, T5 = 3000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic agate = 1'b0, rd_cmd = 1'b0, strobe = 1'b0, wr_ready = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0, rsrc = '0;
  logic [CC_W-1:0] ccsrc = '0;
  logic gret, dbus_en, cc_en, wr_valid, done, cleanup;
  logic [DATA_W-1:0] dbus, wr_data;
  logic [CC_W-1:0] cc;
  int nchk = 0, nerr = 0, acc_n = 0, acc_d = 0;

  always #2.5 clk = ~clk;

  gret_responder #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CC_W(CC_W), .DEV_ADDR(DEV),
    .ACK_DLY(ACKD), .CLEAN_CYC(CLEAN), .READY_MAX(8), .CLK_NS(CLKNS), .T5_NS(T5)
  ) u_gret_responder (
    .clk(clk), .rst_n(rst_n), .agate_i(agate), .addr_i(addr), .rd_cmd_i(rd_cmd),
    .strobe_i(strobe), .wdata_i(wdata), .rdata_src_i(rsrc), .cc_src_i(ccsrc),
    .wr_ready_i(wr_ready), .gret_o(gret), .dbus_o(dbus), .dbus_en_o(dbus_en),
    .cc_o(cc), .cc_en_o(cc_en), .wr_valid_o(wr_valid), .wr_data_o(wr_data),
    .done_o(done), .cleanup_o(cleanup)
  );

  always @(negedge clk) if (wr_valid && wr_ready) begin acc_n++; acc_d = int'(wr_data); end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic txn(input int a, input bit rd, input int sd);
    int n, m, ncl, ndn;
    @(negedge clk);
    addr = ADDR_W'(a); rd_cmd = rd; wr_ready = 1'b1;
    wdata = DATA_W'(a * 13 + sd * 7 + 1); rsrc = ~wdata; ccsrc = CC_W'(a + sd);
    agate = 1'b1; acc_n = 0;
    if (a != DEV) begin
      n = 0;
      for (int i = 0; i < ACKD + 4; i++) begin @(negedge clk); if (gret) n++; end
      chk(n == 0, "R2 foreign address", n, 0);
      agate = 1'b0; @(negedge clk);
      return;
    end
    n = 0;
    do begin @(negedge clk); n++; end while (!gret && n < 20);
    chk(n == 1 + ACKD, "R2 gate-return delay", n, 1 + ACKD);
    chk(cc_en && cc == ccsrc, "R3 cc bus", int'(cc), int'(ccsrc));
    chk(dbus_en == rd, "R3 data enable", int'(dbus_en), int'(rd));
    if (rd) chk(dbus == rsrc, "R3 read data", int'(dbus), int'(rsrc));
    strobe = 1'b1;
    repeat (2) @(negedge clk);
    agate = 1'b0;
    for (int i = 0; i < sd; i++) begin
      @(negedge clk);
      chk(gret && cc_en, "R4 strobe outlasts gate", int'({gret, cc_en}), 3);
    end
    strobe = 1'b0;
    @(negedge clk);
    m = 1;
    chk(!cc_en && !dbus_en && done, "R5 bus release", int'({cc_en, dbus_en, done}), 1);
    ncl = cleanup ? 1 : 0; ndn = 1;
    while (gret && m < 40) begin
      @(negedge clk); m++;
      if (cleanup) ncl++;
      if (done) ndn++;
    end
    chk(m == CLEAN + 2, "R6 gate-return release", m, CLEAN + 2);
    chk(ncl == CLEAN, "R6 cleanup cycles", ncl, CLEAN);
    chk(ndn == 1, "R5 done pulse count", ndn, 1);
    chk(m * CLKNS <= T5, "R9 window", m * CLKNS, T5);
    chk(acc_n == (rd ? 0 : 1), "R7 word count", acc_n, rd ? 0 : 1);
    if (!rd) chk(acc_d == int'(wdata), "R7 word value", acc_d, int'(wdata));
  endtask

  initial begin
    #(200000 * CLKNS);
    nchk++; nerr++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!gret && !dbus_en && !cc_en && !wr_valid && !done && !cleanup, "R1 reset",
        int'({gret, dbus_en, cc_en, wr_valid, done, cleanup}), 0);
    rst_n = 1'b1;
    for (int a = 0; a < (1 << ADDR_W); a++)
      for (int r = 0; r < 2; r++)
        for (int sd = 0; sd < 3; sd++)
          txn(a, r[0], sd);

    // R8: write word held back by the consumer
    @(negedge clk);
    addr = ADDR_W'(DEV); rd_cmd = 1'b0; wr_ready = 1'b0; wdata = 8'hA6; agate = 1'b1;
    repeat (1 + ACKD) @(negedge clk);
    strobe = 1'b1;
    repeat (2) @(negedge clk);
    agate = 1'b0; strobe = 1'b0;
    for (int i = 0; i < CLEAN + 4; i++) begin
      @(negedge clk);
      chk(gret && wr_valid, "R8 held while pending", int'({gret, wr_valid}), 3);
    end
    chk(wr_data == 8'hA6, "R7 pending word", int'(wr_data), 8'hA6);
    wr_ready = 1'b1;
    @(negedge clk);
    chk(gret && !wr_valid, "R8 accepted, still acknowledging", int'({gret, wr_valid}), 2);
    @(negedge clk);
    chk(!gret, "R8 release after accept", int'(gret), 0);

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule